// File: doc/BRIEF.md
# Round-Robin Hardware Thread Scheduler

This block chooses, in every clock cycle, which of eight hardware threads on a barrel-style processor tile may issue one instruction. A thread takes part only when it is ready, not paused, not held by a multi-cycle operation such as a divide, and its last issue lies at least four cycles back. Among the threads that qualify, the choice rotates round-robin. The search starts at the index after the most recently granted thread.

Because of the four-cycle spacing, a tile with four or fewer ready threads gives each of them one slot in every four cycles, and leaves the remaining slots empty. With more than four ready threads, every slot is filled and the threads share the slots equally. With all eight ready, each thread issues once in every eight cycles. The grant is presented in the same cycle as the inputs that cause it. It comes both as a one-hot vector and as an index, with a valid strobe.

Each thread has its own pacing state machine with two states. `PACE_OPEN` means the thread may issue. `PACE_HOLD` means the thread is waiting out its spacing. The transition `OPEN->HOLD` is taken when the thread is granted. The transition `HOLD->HOLD` is taken while the countdown is above one. The transition `HOLD->OPEN` is taken on the last cycle of the countdown. The arbiter keeps a last-grant pointer. The pointer moves only on a cycle that issues. It stays unchanged on a bubble.

Top module: `thread_issue_sched`

## Requirements
- R1: After reset every pacing counter is clear and the last-grant pointer is 7. The first cycle with all threads ready therefore grants thread 0 at once.
- R2: No thread is granted more than once in any four consecutive cycles.
- R3: With four or fewer threads eligible, each issues every fourth cycle. Three steadily ready threads get ten grants each in forty cycles.
- R4: With more than four threads ready, slots are shared equally. Eight ready threads get eight grants each in 64 cycles, and five ready threads get ten each in 50 cycles.
- R5: The granted index is the first eligible thread found when searching upward, with wrap-around, starting at the last granted index plus one.
- R6: A thread whose ready bit is 0, or whose pause bit is 1, is never granted.
- R7: A thread whose busy bit is 1 is never granted, and its slots go to the other threads. With eight ready threads and one held busy, every cycle still issues.
- R8: When no thread is eligible, grant_valid is 0 and grant_onehot is all zeros.
- R9: grant_onehot has at most one bit set. When grant_valid is 1, that bit is at position grant_idx.
- R10: The spacing is counted from the last issue regardless of pause, busy or ready. A thread granted in cycle t, paused in cycles t+1 and t+2, and ready again at t+3 is not granted at t+3 and is granted at t+4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thr_ready | input | 8 | Per-thread: has an instruction ready |
| thr_pause | input | 8 | Per-thread: paused, must not issue |
| thr_busy | input | 8 | Per-thread: held by a multi-cycle operation |
| grant_onehot | output | 8 | One-hot issue grant for this cycle |
| grant_idx | output | 3 | Index of the granted thread |
| grant_valid | output | 1 | A thread issues this cycle |

## Verification
Two functions can decide the same cycle together: a thread's spacing countdown reaching its end, and the round-robin pointer reaching that thread's turn. The busy or pause release of a neighbouring thread can also land in that cycle. Random sparse busy and pause pulses over mixed ready masks provoke these coincidences repeatedly. A directed pause across a countdown forces one on purpose. Each cycle is judged against a bench model that recomputes eligibility from the spacing rule and picks the next index after the last grant.

// File: rtl/sched_pkg.sv
package sched_pkg;

    typedef enum logic {
        PACE_OPEN = 1'b0,
        PACE_HOLD = 1'b1
    } pace_state_e;

endpackage

// File: rtl/thread_pacer.sv
module thread_pacer
    import sched_pkg::*;
#(
    parameter int MIN_GAP = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic issue,
    output logic open
);

    localparam int CW = (MIN_GAP > 2) ? $clog2(MIN_GAP) : 1;

    pace_state_e     state_q, state_d;
    logic [CW-1:0]   cd_q, cd_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        cd_d    = cd_q;
        unique case (state_q)
            PACE_OPEN: begin
                if (issue && MIN_GAP > 1) begin
                    state_d = PACE_HOLD;
                    cd_d    = CW'(MIN_GAP - 1);
                end
            end
            PACE_HOLD: begin
                if (cd_q <= CW'(1)) begin
                    state_d = PACE_OPEN;
                    cd_d    = '0;
                end else begin
                    cd_d = cd_q - CW'(1);
                end
            end
            default: begin
                state_d = PACE_OPEN;
                cd_d    = '0;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PACE_OPEN;
            cd_q    <= '0;
        end else begin
            state_q <= state_d;
            cd_q    <= cd_d;
        end
    end

    // outputs
    always_comb begin
        open = (state_q == PACE_OPEN);
    end

    // R2: the arbiter must never grant a thread that is still holding
    p_hold_blocks_issue_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PACE_HOLD) |-> !issue);

endmodule

// File: rtl/rr_picker.sv
module rr_picker #(
    parameter int N = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         elig,
    output logic [N-1:0]         gnt_oh,
    output logic [$clog2(N)-1:0] gnt_idx,
    output logic                 gnt_vld
);

    localparam int IW = $clog2(N);

    logic [IW-1:0] last_q;
    logic [IW-1:0] pick;
    logic          found;

    // rotating search starting just after the last grant
    always_comb begin
        found = 1'b0;
        pick  = '0;
        for (int k = 1; k <= N; k++) begin
            int c;
            c = (int'(last_q) + k) % N;
            if (!found && elig[c]) begin
                found = 1'b1;
                pick  = IW'(c);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q <= IW'(N - 1);
        end else if (found) begin
            last_q <= pick;
        end
    end

    always_comb begin
        gnt_vld = found;
        gnt_idx = pick;
        gnt_oh  = '0;
        if (found) gnt_oh[pick] = 1'b1;
    end

    // R5: a bubble leaves the pointer where it was
    p_ptr_hold_on_bubble_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !found |=> $stable(last_q));

    // R9: at most one grant bit
    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_oh));

endmodule

// File: rtl/thread_issue_sched.sv
module thread_issue_sched #(
    parameter int NUM_THREADS = 8,
    parameter int MIN_GAP     = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_THREADS-1:0]         thr_ready,
    input  logic [NUM_THREADS-1:0]         thr_pause,
    input  logic [NUM_THREADS-1:0]         thr_busy,
    output logic [NUM_THREADS-1:0]         grant_onehot,
    output logic [$clog2(NUM_THREADS)-1:0] grant_idx,
    output logic                           grant_valid
);

    localparam int IW = $clog2(NUM_THREADS);
    localparam int GW = $clog2(MIN_GAP + 1);

    logic [NUM_THREADS-1:0] open_w;
    logic [NUM_THREADS-1:0] elig_w;
    logic [NUM_THREADS-1:0] oh_w;
    logic [IW-1:0]          idx_w;
    logic                   vld_w;

    genvar g;
    generate
        for (g = 0; g < NUM_THREADS; g++) begin : g_pace
            thread_pacer #(.MIN_GAP(MIN_GAP)) u_pacer (
                .clk   (clk),
                .rst_n (rst_n),
                .issue (oh_w[g]),
                .open  (open_w[g])
            );
        end
    endgenerate

    always_comb begin
        elig_w = thr_ready & ~thr_pause & ~thr_busy & open_w;
    end

    rr_picker #(.N(NUM_THREADS)) u_pick (
        .clk     (clk),
        .rst_n   (rst_n),
        .elig    (elig_w),
        .gnt_oh  (oh_w),
        .gnt_idx (idx_w),
        .gnt_vld (vld_w)
    );

    always_comb begin
        grant_onehot = oh_w;
        grant_idx    = idx_w;
        grant_valid  = vld_w;
    end

    // R6, R7: only ready, unpaused, non-busy threads are granted
    p_grant_qualified_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_onehot & ~(thr_ready & ~thr_pause)) == '0);
    p_busy_not_granted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_onehot & thr_busy) == '0);

    // R8: bubble exactly when nothing qualifies
    p_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_w == '0) |-> (!grant_valid && grant_onehot == '0));
    p_no_waste_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (elig_w != '0) |-> grant_valid);

    // R9: index agrees with the one-hot vector
    p_idx_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid |-> grant_onehot[grant_idx]);

    // R2: independent spacing monitor per thread
    generate
        for (g = 0; g < NUM_THREADS; g++) begin : g_gapmon
            logic [GW-1:0] since_q;
            always_ff @(posedge clk) begin
                if (!rst_n)                       since_q <= GW'(MIN_GAP);
                else if (grant_onehot[g])         since_q <= GW'(1);
                else if (since_q < GW'(MIN_GAP))  since_q <= since_q + GW'(1);
            end
            p_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
                grant_onehot[g] |-> (since_q >= GW'(MIN_GAP)));
        end
    endgenerate

endmodule

// File: tb/thread_issue_sched_test.sv
`timescale 1ns/1ps
module thread_issue_sched_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] rdy, pau, bsy;
    logic [7:0] grant_onehot;
    logic [2:0] grant_idx;
    logic       grant_valid;

    always #2.5 clk = ~clk;

    thread_issue_sched uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .thr_ready    (rdy),
        .thr_pause    (pau),
        .thr_busy     (bsy),
        .grant_onehot (grant_onehot),
        .grant_idx    (grant_idx),
        .grant_valid  (grant_valid)
    );

    int total = 0;
    int bad   = 0;
    int mcd[8];
    int mlast;
    int cyc;
    int last_gnt[8];
    int gcount[8];
    int vcount;

    function automatic int pick(logic [7:0] e, int last);
        for (int k = 1; k <= 8; k++) begin
            int c;
            c = (last + k) % 8;
            if (e[c]) return c;
        end
        return -1;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_counts();
        for (int i = 0; i < 8; i++) gcount[i] = 0;
        vcount = 0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; rdy = '0; pau = '0; bsy = '0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            mcd[i] = 0;
            last_gnt[i] = -100;
        end
        mlast = 7;
        clear_counts();
    endtask

    // one cycle: drive, sample mid-cycle, compare with model, advance model
    task automatic cycle(logic [7:0] r, logic [7:0] p, logic [7:0] b);
        logic [7:0] e;
        int x;
        @(posedge clk);
        #1 rdy = r; pau = p; bsy = b;
        #1;
        e = '0;
        for (int i = 0; i < 8; i++)
            e[i] = r[i] & ~p[i] & ~b[i] & (mcd[i] == 0);
        x = pick(e, mlast);
        check(grant_valid == (x >= 0), "R8", "valid", int'(grant_valid), int'(x >= 0));
        if (x >= 0) begin
            check(int'(grant_idx) == x, "R5", "idx", int'(grant_idx), x);
            check(grant_onehot == (8'h1 << x), "R9", "onehot", int'(grant_onehot), 1 << x);
        end else begin
            check(grant_onehot == 8'h00, "R8", "onehot", int'(grant_onehot), 0);
        end
        for (int i = 0; i < 8; i++) begin
            if (grant_onehot[i]) begin
                check(cyc - last_gnt[i] >= 4, "R2", "gap", cyc - last_gnt[i], 4);
                last_gnt[i] = cyc;
                gcount[i]++;
            end
        end
        if (grant_valid) vcount++;
        for (int i = 0; i < 8; i++) begin
            if (i == x) mcd[i] = 3;
            else if (mcd[i] > 0) mcd[i]--;
        end
        if (x >= 0) mlast = x;
        cyc++;
    endtask

    initial begin
        #(200000 * 5);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] r, p, b;
        cyc = 0;
        void'($urandom(32'd20240611));

        // R1: reset state
        do_reset();
        #1;
        check(!grant_valid && grant_onehot == 8'h00, "R1", "idle after reset",
              int'(grant_onehot), 0);
        cycle(8'hFF, 8'h00, 8'h00);
        check(grant_valid && grant_idx == 3'd0, "R1", "first grant idx",
              int'(grant_idx), 0);

        // R3: three ready threads, full rate
        do_reset();
        repeat (40) cycle(8'h07, 8'h00, 8'h00);
        for (int i = 0; i < 3; i++)
            check(gcount[i] == 10, "R3", "grants of three", gcount[i], 10);

        // R4: eight ready threads share equally
        do_reset();
        repeat (64) cycle(8'hFF, 8'h00, 8'h00);
        for (int i = 0; i < 8; i++)
            check(gcount[i] == 8, "R4", "grants of eight", gcount[i], 8);

        // R4: five ready threads
        do_reset();
        repeat (50) cycle(8'h1F, 8'h00, 8'h00);
        for (int i = 0; i < 5; i++)
            check(gcount[i] == 10, "R4", "grants of five", gcount[i], 10);

        // R7: one busy thread, slots go to the rest
        do_reset();
        repeat (24) cycle(8'hFF, 8'h00, 8'h08);
        check(gcount[3] == 0, "R7", "busy thread grants", gcount[3], 0);
        check(vcount == 24, "R7", "slots used", vcount, 24);

        // R6: paused upper half, not-ready thread 1
        clear_counts();
        repeat (20) cycle(8'hFD, 8'hF0, 8'h00);
        for (int i = 4; i < 8; i++)
            check(gcount[i] == 0, "R6", "paused grants", gcount[i], 0);
        check(gcount[1] == 0, "R6", "not-ready grants", gcount[1], 0);

        // R8: everything paused
        clear_counts();
        repeat (6) cycle(8'hFF, 8'hFF, 8'h00);
        check(vcount == 0, "R8", "bubbles", vcount, 0);

        // R10: pause during spacing does not reset or extend it
        do_reset();
        cycle(8'h01, 8'h00, 8'h00);
        check(grant_valid && grant_idx == 3'd0, "R10", "issue at t", int'(grant_valid), 1);
        cycle(8'h01, 8'h01, 8'h00);
        cycle(8'h01, 8'h01, 8'h00);
        cycle(8'h01, 8'h00, 8'h00);
        check(!grant_valid, "R10", "no issue at t+3", int'(grant_valid), 0);
        cycle(8'h01, 8'h00, 8'h00);
        check(grant_valid && grant_idx == 3'd0, "R10", "issue at t+4", int'(grant_valid), 1);

        // random mix: spacing expiry meeting pointer turn and busy/pause release
        do_reset();
        for (int n = 0; n < 3000; n++) begin
            r = 8'($urandom) | 8'($urandom);
            p = 8'($urandom) & 8'($urandom) & 8'($urandom);
            b = 8'($urandom) & 8'($urandom) & 8'($urandom);
            cycle(r, p, b);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule